// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs. Software sets it up through a plain 32-bit register bus: address, write data, a write strobe, a read strobe and read data. Each access completes in one cycle. Every channel has a control word with an enable bit and a 14-bit prescaler, a 16-bit duty value and a 16-bit period value. A single master enable word gates all four channels at once.

A running channel divides the clock by (prescale + 1) to form a tick. A period counter advances on each tick and wraps after `period` ticks. The output is high while the counter is below the duty value. Duty and period writes land in the visible registers at once. The waveform picks them up only at the next period wrap, so an update never produces a torn cycle. A channel that is off is held in a clean idle state and starts a fresh period when it is turned on.

Top module: `pwm_quad`

## Requirements
- R1: Channel n (n = 0..3) has its control word at byte address n*0x10, its duty word at n*0x10+0x4 and its period word at n*0x10+0x8. The master word is at 0x3C. Any other address reads as zero and ignores writes.
- R2: A control word stores the enable in bit 0 and the prescaler in bits 15:2. Duty and period words store bits 15:0. The master word stores bit 0. Every stored field reads back the last value written and every other bit reads as zero. `bus_rdata` is valid in the same cycle as `bus_rd` and is zero when `bus_rd` is low.
- R3: Synchronous reset clears every register and drives all four outputs low.
- R4: A channel is idle whenever its enable bit is clear or the master bit is clear. An idle channel drives its output low from the second clock edge after the register write that made it idle. While idle it holds its counters at zero.
- R5: A running channel with prescale P, period PV and duty DC advances its period counter once every P+1 clocks. The counter wraps after PV ticks, so one period lasts (P+1)*PV clocks. The output is high while the counter is below DC.
- R6: Enabling a channel starts a fresh period. The output first shows counter value 0 one clock after the enabling write edge, and that state lasts P+1 clocks.
- R7: A duty value equal to or greater than the period value gives a constant high output. A duty value of 0 gives a constant low output.
- R8: A period value of 0 keeps the channel idle, with its output low, even when both enables are set.
- R9: Duty and period values written while a channel runs take effect only when the period counter wraps. The period in progress completes with the old values.
- R10: With the master bit clear, an enabled channel stays low. Setting the master bit starts that channel with a fresh period, timed as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The hardest situation to reach is a duty and period update that lands in the middle of a running period. The old values must finish that period before the new ones apply. To reach it, the stimulus enables a channel and, on the next two clock edges, writes a new duty and a new period. The expected waveform then changes shape exactly at the first wrap, and a value that leaked through early would be visible from the third sample onward. The second hardest case is the master gate. The bench enables a channel while the master bit is clear, confirms the output stays low, and then checks that setting the master bit starts a fresh period with the same one-cycle latency as a channel enable.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam int NUM_CH   = 4;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 14;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CH_LSB   = 4;
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int PRE_LSB  = 2;

    localparam logic [ADDR_W-1:0] MASTER_ADDR = 8'h3C;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_DUTY   = 2'd1,
        SLOT_PERIOD = 2'd2,
        SLOT_NONE   = 2'd3
    } slot_e;

    typedef struct packed {
        logic             en;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] per;
    } chan_cfg_t;

    function automatic slot_e slot_of(input logic [CH_LSB-1:0] off);
        case (off)
            4'h0:    return SLOT_CTRL;
            4'h4:    return SLOT_DUTY;
            4'h8:    return SLOT_PERIOD;
            default: return SLOT_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input chan_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[PRE_LSB +: PRE_W] = c.pre;
        return w;
    endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           wr,
    input  logic                           rd,
    output logic [DATA_W-1:0]              rdata,
    output chan_cfg_t [NUM_CH-1:0]         cfg,
    output logic                           master_en
);

    localparam int HI_LSB = CH_LSB + CH_IDX_W;

    slot_e               slot;
    logic [CH_IDX_W-1:0] idx;
    logic                in_range;
    logic [NUM_CH-1:0]   hit;
    logic                unused_bits;

    assign slot        = slot_of(addr[CH_LSB-1:0]);
    assign idx         = addr[CH_LSB +: CH_IDX_W];
    assign in_range    = (addr[ADDR_W-1:HI_LSB] == '0) && (int'(idx) < NUM_CH);
    assign unused_bits = ^{wdata[DATA_W-1:CNT_W], wdata[1]};

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            hit[i] = in_range && (int'(idx) == i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_en <= 1'b0;
        end else if (wr && addr == MASTER_ADDR) begin
            master_en <= wdata[0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (wr && hit[g]) begin
                case (slot)
                    SLOT_CTRL: begin
                        cfg[g].en  <= wdata[0];
                        cfg[g].pre <= wdata[PRE_LSB +: PRE_W];
                    end
                    SLOT_DUTY:   cfg[g].duty <= wdata[CNT_W-1:0];
                    SLOT_PERIOD: cfg[g].per  <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == MASTER_ADDR) begin
                rdata[0] = master_en;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (hit[i]) begin
                        case (slot)
                            SLOT_CTRL:   rdata = pack_ctrl(cfg[i]);
                            SLOT_DUTY:   rdata[CNT_W-1:0] = cfg[i].duty;
                            SLOT_PERIOD: rdata[CNT_W-1:0] = cfg[i].per;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
    import pwmq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] per,
    output logic             out
);

    logic             active;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sh_duty;
    logic [CNT_W-1:0] sh_per;
    logic [CNT_W:0]   cnt_nxt;
    logic             tick;
    logic             wrap;

    assign cnt_nxt = {1'b0, cnt} + 1'b1;
    assign tick    = (pre_cnt >= pre);
    assign wrap    = (cnt_nxt >= {1'b0, sh_per});

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            pre_cnt <= '0;
            cnt     <= '0;
            sh_duty <= '0;
            sh_per  <= '0;
        end else if (!run || !active) begin
            // idle, or first cycle of a fresh period: counters cleared, shadows loaded
            active  <= run;
            pre_cnt <= '0;
            cnt     <= '0;
            sh_duty <= duty;
            sh_per  <= per;
        end else if (tick) begin
            pre_cnt <= '0;
            if (wrap) begin
                cnt     <= '0;
                sh_duty <= duty;
                sh_per  <= per;
            end else begin
                cnt <= cnt_nxt[CNT_W-1:0];
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign out = active && (cnt < sh_duty);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwmq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_out
);

    chan_cfg_t [NUM_CH-1:0] cfg;
    logic                   master_en;
    logic [NUM_CH-1:0]      ch_run;
    logic [NUM_CH-1:0]      per_zero;

    pwmq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .master_en (master_en)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign per_zero[g] = (cfg[g].per == '0);
        assign ch_run[g]   = master_en && cfg[g].en && !per_zero[g];

        pwmq_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .run  (ch_run[g]),
            .pre  (cfg[g].pre),
            .duty (cfg[g].duty),
            .per  (cfg[g].per),
            .out  (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
    import pwmq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [3:0]        pwm_out,
    input logic [NUM_CH-1:0] ch_run,
    input logic [NUM_CH-1:0] per_zero,
    input logic              master_en
);

    assert_reset_low_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == '0));

    assert_master_store_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == MASTER_ADDR) |=> (master_en == $past(bus_wdata[0])));

    assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[3:0] == 4'h0 && bus_addr[7:6] == 2'b00)
            |-> (bus_rdata[31:16] == '0 && bus_rdata[1] == 1'b0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
            !ch_run[g] |=> !pwm_out[g]);

        assert_zero_period_R8: assert property (@(posedge clk) disable iff (rst)
            per_zero[g] |=> !pwm_out[g]);
    end

endmodule

bind pwm_quad pwmq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_run    (ch_run),
    .per_zero  (per_zero),
    .master_en (master_en)
);

// File: tb/pwm_quad_test.sv
module pwm_quad_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [3:0] mask;
        logic [3:0] val;
        string      req;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    pwm_quad uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [7:0] a_ctrl(int ch);   return 8'(ch * 16);     endfunction
    function automatic logic [7:0] a_duty(int ch);   return 8'(ch * 16 + 4); endfunction
    function automatic logic [7:0] a_per(int ch);    return 8'(ch * 16 + 8); endfunction

    function automatic logic exp_bit(int j, int p, int pv, int dc);
        if (pv == 0) return 1'b0;
        return ((j / (p + 1)) % pv) < dc;
    endfunction

    // monitor: pops one expectation per cycle, mid-cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ((pwm_out & e.mask) !== e.val) begin
                    errors++;
                    $display("FAIL %s: pwm_out&mask=%b expected=%b", e.req, pwm_out & e.mask, e.val);
                end
            end
        end
    end

    task automatic push_wave(int ch, int j0, int n, int p, int pv, int dc, string req);
        for (int j = j0; j < j0 + n; j++) begin
            exp_t e;
            e.mask = 4'(1 << ch);
            e.val  = exp_bit(j, p, pv, dc) ? 4'(1 << ch) : 4'b0;
            e.req  = req;
            q.push_back(e);
        end
    endtask

    task automatic push_const(int ch, int n, logic b, string req);
        for (int j = 0; j < n; j++) begin
            exp_t e;
            e.mask = 4'(1 << ch);
            e.val  = b ? 4'(1 << ch) : 4'b0;
            e.req  = req;
            q.push_back(e);
        end
    endtask

    // caller stands at a negedge; returns at the negedge after the write edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] expv, string req);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        checks++;
        if (bus_rdata !== expv) begin
            errors++;
            $display("FAIL %s: read 0x%02h = 0x%08h expected=0x%08h", req, a, bus_rdata, expv);
        end
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: run still active=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3: reset state
        checks++;
        if (pwm_out !== 4'b0) begin
            errors++;
            $display("FAIL R3: pwm_out=%b expected=0000", pwm_out);
        end
        rd_chk(a_ctrl(0), 32'h0, "R3");
        rd_chk(a_duty(2), 32'h0, "R3");
        rd_chk(a_per(3),  32'h0, "R3");
        rd_chk(8'h3C,     32'h0, "R3");
        @(negedge clk);

        // R2: readback masks
        wr(a_ctrl(1), 32'hFFFF_FFFF);
        rd_chk(a_ctrl(1), 32'h0000_FFFD, "R2");
        @(negedge clk);
        wr(a_duty(1), 32'hABCD_1234);
        rd_chk(a_duty(1), 32'h0000_1234, "R2");
        @(negedge clk);
        wr(a_per(2), 32'h5555_AAAA);
        rd_chk(a_per(2), 32'h0000_AAAA, "R2");
        rd_chk(a_per(1), 32'h0, "R1");
        @(negedge clk);
        wr(8'h3C, 32'hFFFF_FFFE);
        rd_chk(8'h3C, 32'h0, "R2");
        @(negedge clk);
        // R1: holes ignore writes and read zero
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h0, "R1");
        rd_chk(a_ctrl(0), 32'h0, "R1");
        rd_chk(8'h40, 32'h0, "R1");
        @(negedge clk);
        wr(a_ctrl(1), 32'h0);
        wr(a_duty(1), 32'h0);
        wr(a_per(2), 32'h0);
        wr(8'h3C, 32'h1);
        rd_chk(8'h3C, 32'h1, "R2");
        @(negedge clk);

        // R5/R6: channel 0, prescale 0, PV 5, DC 3
        wr(a_duty(0), 32'd3);
        wr(a_per(0), 32'd5);
        wr(a_ctrl(0), 32'h1);
        push_wave(0, 0, 15, 0, 5, 3, "R5/R6");
        settle();
        // R4: disable mid-run
        wr(a_ctrl(0), 32'h0);
        push_const(0, 4, 1'b0, "R4");
        settle();

        // R5: channel 2, prescale 2, PV 4, DC 1
        wr(a_duty(2), 32'd1);
        wr(a_per(2), 32'd4);
        wr(a_ctrl(2), (32'd2 << 2) | 32'h1);
        push_wave(2, 0, 30, 2, 4, 1, "R5");
        settle();
        wr(a_ctrl(2), 32'h0);
        push_const(2, 3, 1'b0, "R4");
        settle();

        // R7: duty above period -> constant high
        wr(a_duty(1), 32'd7);
        wr(a_per(1), 32'd3);
        wr(a_ctrl(1), 32'h1);
        push_const(1, 12, 1'b1, "R7");
        settle();
        wr(a_ctrl(1), 32'h0);
        settle();
        // R7: duty 0 -> constant low
        wr(a_duty(1), 32'd0);
        wr(a_ctrl(1), 32'h1);
        push_const(1, 8, 1'b0, "R7");
        settle();
        wr(a_ctrl(1), 32'h0);
        settle();

        // R8: period 0 keeps channel low
        wr(a_duty(1), 32'd5);
        wr(a_per(1), 32'd0);
        wr(a_ctrl(1), 32'h1);
        push_const(1, 8, 1'b0, "R8");
        settle();
        wr(a_ctrl(1), 32'h0);
        settle();

        // R9: mid-period update waits for the wrap
        wr(a_duty(0), 32'd2);
        wr(a_per(0), 32'd4);
        wr(a_ctrl(0), 32'h1);
        wr(a_duty(0), 32'd3);
        wr(a_per(0), 32'd6);
        for (int j = 2; j < 16; j++) begin
            exp_t e;
            logic b;
            b = (j < 4) ? exp_bit(j, 0, 4, 2) : exp_bit(j - 4, 0, 6, 3);
            e.mask = 4'b0001;
            e.val  = {3'b0, b};
            e.req  = "R9";
            q.push_back(e);
        end
        settle();
        wr(a_ctrl(0), 32'h0);
        settle();

        // R10: master gate
        wr(8'h3C, 32'h0);
        wr(a_duty(3), 32'd2);
        wr(a_per(3), 32'd3);
        wr(a_ctrl(3), (32'd1 << 2) | 32'h1);
        push_const(3, 6, 1'b0, "R10");
        settle();
        wr(8'h3C, 32'h1);
        push_wave(3, 0, 18, 1, 3, 2, "R10/R6");
        settle();
        wr(8'h3C, 32'h0);
        push_const(3, 4, 1'b0, "R4");
        settle();
        wr(a_ctrl(3), 32'h0);
        settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule